// File: doc/BRIEF.md
# SPI Status Flags and Interrupt Logic

This block keeps the sticky event flags of a small SPI peripheral and the interrupt request derived from them. It sits between a processor bus port and an SPI shift engine. The shift engine reports five kinds of event as one-cycle pulses: transfer done, mode fault, read overrun, write collision and slave abort. Each pulse sets a flag, and the flag stays set until software runs the clearing sequence that belongs to it.

Some flags clear on a plain status read. The others need two steps: a status read first, then a later write to the control register or an access to the data register. The data register itself is not part of this block. Any access to it arrives only as a strobe.

The block also holds a small control register. That register provides the interrupt enable and the word-length selection, and the block turns the word-length selection into an effective bit count for the shift engine.

Top module: `spi_flag_ctrl`

## Requirements
- R1: After a synchronous active-low reset, every flag and every control field is 0, `irq` is 0 and `xfer_bits` is 8.
- R2: A read at byte address 4 returns slave abort in bit 3, mode fault in bit 4, read overrun in bit 5, write collision in bit 6 and transfer done in bit 7. Bits 2:0 and 15:8 read as 0.
- R3: A status read clears the slave-abort and read-overrun flags at the next clock edge.
- R4: The mode-fault flag clears only on a write to address 0 that comes after a status read which saw the flag set. A control write with no such read leaves the flag set.
- R5: The write-collision and transfer-done flags clear only on a `data_acc` strobe that comes after a status read which saw them set. A strobe with no such read leaves them set.
- R6: A status read arms only the flags that are set during that read. A flag that sets after the read is not cleared by the following clearing access.
- R7: An event pulse always sets its flag and drops that flag's armed state. This holds even in the same cycle as a clearing access, so a later clearing access needs a new status read first.
- R8: `irq` is 1 exactly when control bit 7 is 1 and the transfer-done or mode-fault flag is set. The other flags never raise `irq`.
- R9: When control bit 2 is 1, control bits 11:8 set `xfer_bits`: codes 8 to 15 give that count and code 0 gives 16. When control bit 2 is 0, or the code is 1 to 7, `xfer_bits` is 8.
- R10: A read at address 0 returns the stored control bits 2, 7 and 11:8 with every other bit 0. Writes and reads at any address other than 0 and 4 have no effect and read 0. `bus_rdata` is 0 when `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 4 | Byte address of the register access |
| bus_rd | input | 1 | Read strobe, one cycle per read |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, combinational, valid while `bus_rd` is high |
| data_acc | input | 1 | Strobe for a read or write of the data register |
| ev_done | input | 1 | Transfer-complete pulse from the shift engine |
| ev_modf | input | 1 | Mode-fault pulse |
| ev_rovr | input | 1 | Read-overrun pulse |
| ev_wcol | input | 1 | Write-collision pulse |
| ev_abrt | input | 1 | Slave-abort pulse |
| irq | output | 1 | Level interrupt request |
| xfer_bits | output | 5 | Effective bits per transfer, 8 to 16 |

## Verification
The assertions check the following on every cycle:
- a flag rises only in the cycle after its event pulse;
- each flag falls only in the cycle after its own clearing access;
- an event always outweighs a clearing access in the same cycle;
- `irq` only ever has a flag source behind it;
- `xfer_bits` stays within 8 to 16;
- the reserved status bits read as 0.

Some behaviour depends on the order of accesses, and only the bench's scenarios can show it:
- the two-step sequences;
- the rule that a read arms only flags already set;
- the loss of the armed state after a colliding event;
- the full decoding of the word-length codes.

// File: rtl/spi_flag_pkg.sv
// Package: shared constants and types for the SPI flag block.
// Assumes five flags, indexed in status-bit order starting at STAT_LSB.
package spi_flag_pkg;
    localparam int NFLAG     = 5;
    localparam int F_ABRT    = 0;
    localparam int F_MODF    = 1;
    localparam int F_ROVR    = 2;
    localparam int F_WCOL    = 3;
    localparam int F_DONE    = 4;
    localparam int STAT_LSB  = 3;
    // Flags that need a read followed by a separate clearing access.
    localparam logic [NFLAG-1:0] TWO_STEP_MASK = 5'b11010;

    localparam int CTRL_WSEL_BIT = 2;
    localparam int CTRL_IEN_BIT  = 7;
    localparam int CTRL_CODE_LSB = 8;
    localparam int CODE_W        = 4;

    typedef struct packed {
        logic [CODE_W-1:0] code;  // bits-per-transfer code
        logic              ien;   // interrupt enable
        logic              wsel;  // word-length selection enable
    } ctrl_t;
endpackage

// File: rtl/spi_ctrl_reg.sv
// Module: control register holding the interrupt enable and the word-length code.
// Also decodes the effective bits per transfer.
// Assumes the write strobe is already qualified by the address.
module spi_ctrl_reg
    import spi_flag_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output ctrl_t             ctrl,
    output logic [DATA_W-1:0] rd_word,
    output logic [CNT_W-1:0]  bit_count
);
    localparam int MIN_BITS = 8;
    localparam int MAX_BITS = 16;

    // Stores the defined control fields; reserved bits are dropped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
        end else if (wr_en) begin
            ctrl.code <= wdata[CTRL_CODE_LSB +: CODE_W];
            ctrl.ien  <= wdata[CTRL_IEN_BIT];
            ctrl.wsel <= wdata[CTRL_WSEL_BIT];
        end
    end

    // Builds the read-back word with the reserved bits at 0.
    always_comb begin
        rd_word = '0;
        rd_word[CTRL_CODE_LSB +: CODE_W] = ctrl.code;
        rd_word[CTRL_IEN_BIT]            = ctrl.ien;
        rd_word[CTRL_WSEL_BIT]           = ctrl.wsel;
    end

    // Decodes the effective bit count for the shift engine.
    always_comb begin
        if (!ctrl.wsel) begin
            bit_count = CNT_W'(MIN_BITS);
        end else if (ctrl.code == '0) begin
            bit_count = CNT_W'(MAX_BITS);
        end else if (ctrl.code[CODE_W-1]) begin
            bit_count = CNT_W'(ctrl.code);
        end else begin
            bit_count = CNT_W'(MIN_BITS);
        end
    end
endmodule

// File: rtl/spi_flag_cell.sv
// Module: one sticky status flag.
// TWO_STEP=0 clears on a status read. TWO_STEP=1 clears on a clearing access after an
// arming read. The arming read arms the flag only if it was set during that read.
// An event always wins and drops the armed state.
module spi_flag_cell #(
    parameter bit TWO_STEP = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic event_i,
    input  logic stat_rd,
    input  logic clr_acc,
    output logic flag_o,
    output logic armed_o
);
    generate
        if (TWO_STEP) begin : g_two
            // Sets on an event, arms on a read, clears on an armed access.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag_o  <= 1'b0;
                    armed_o <= 1'b0;
                end else if (event_i) begin
                    flag_o  <= 1'b1;
                    armed_o <= 1'b0;
                end else if (clr_acc && armed_o) begin
                    flag_o  <= 1'b0;
                    armed_o <= 1'b0;
                end else if (stat_rd) begin
                    armed_o <= flag_o;
                end
            end
        end else begin : g_one
            // Sets on an event and clears on a status read.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    flag_o <= 1'b0;
                end else if (event_i) begin
                    flag_o <= 1'b1;
                end else if (stat_rd) begin
                    flag_o <= 1'b0;
                end
            end
            assign armed_o = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/spi_flag_bank.sv
// Module: an array of flag cells. Each cell picks its clearing style from the mask.
// Assumes the per-flag clearing-access vector is already routed by the caller.
module spi_flag_bank #(
    parameter int               N    = 5,
    parameter logic [N-1:0]     MASK = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] events,
    input  logic         stat_rd,
    input  logic [N-1:0] clr_acc,
    output logic [N-1:0] flags,
    output logic [N-1:0] armed
);
    generate
        for (genvar i = 0; i < N; i++) begin : g_cell
            spi_flag_cell #(.TWO_STEP(MASK[i])) u_cell (
                .clk     (clk),
                .rst_n   (rst_n),
                .event_i (events[i]),
                .stat_rd (stat_rd),
                .clr_acc (clr_acc[i]),
                .flag_o  (flags[i]),
                .armed_o (armed[i])
            );
        end
    endgenerate
endmodule

// File: rtl/spi_flag_ctrl.sv
// Module: top of the SPI status-flag block.
// Decodes bus accesses, routes the clearing accesses, muxes read data and drives the
// level interrupt. Assumes single-cycle strobes and byte addresses 0 (control) and 4 (status).
module spi_flag_ctrl
    import spi_flag_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              data_acc,
    input  logic              ev_done,
    input  logic              ev_modf,
    input  logic              ev_rovr,
    input  logic              ev_wcol,
    input  logic              ev_abrt,
    output logic              irq,
    output logic [CNT_W-1:0]  xfer_bits
);
    localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(4);

    logic              ctrl_wr;
    logic              stat_rd;
    logic              ctrl_rd;
    ctrl_t             ctrl;
    logic [DATA_W-1:0] ctrl_word;
    logic [NFLAG-1:0]  events;
    logic [NFLAG-1:0]  clr_acc;
    logic [NFLAG-1:0]  flags;
    logic [NFLAG-1:0]  armed;

    // Qualifies the strobes with the register address.
    always_comb begin
        ctrl_wr = bus_wr && (bus_addr == CTRL_ADDR);
        ctrl_rd = bus_rd && (bus_addr == CTRL_ADDR);
        stat_rd = bus_rd && (bus_addr == STAT_ADDR);
    end

    // Gathers the event pulses into flag-index order.
    always_comb begin
        events         = '0;
        events[F_ABRT] = ev_abrt;
        events[F_MODF] = ev_modf;
        events[F_ROVR] = ev_rovr;
        events[F_WCOL] = ev_wcol;
        events[F_DONE] = ev_done;
    end

    // Routes to each two-step flag its own clearing access.
    always_comb begin
        clr_acc         = '0;
        clr_acc[F_MODF] = ctrl_wr;
        clr_acc[F_WCOL] = data_acc;
        clr_acc[F_DONE] = data_acc;
    end

    spi_ctrl_reg #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (ctrl_wr),
        .wdata     (bus_wdata),
        .ctrl      (ctrl),
        .rd_word   (ctrl_word),
        .bit_count (xfer_bits)
    );

    spi_flag_bank #(.N(NFLAG), .MASK(TWO_STEP_MASK)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .events  (events),
        .stat_rd (stat_rd),
        .clr_acc (clr_acc),
        .flags   (flags),
        .armed   (armed)
    );

    // Selects read data; returns 0 for no read and for unmapped addresses.
    always_comb begin
        bus_rdata = '0;
        if (ctrl_rd) begin
            bus_rdata = ctrl_word;
        end else if (stat_rd) begin
            bus_rdata[STAT_LSB +: NFLAG] = flags;
        end
    end

    // Drives the level interrupt from the enabled flag sources.
    always_comb begin
        irq = ctrl.ien && (flags[F_DONE] || flags[F_MODF]);
    end
endmodule

// File: rtl/spi_flag_ctrl_chk.sv
// Module: assertion checker for spi_flag_ctrl, attached with bind.
// Reads the top-level ports and the flag vector.
module spi_flag_ctrl_chk
    import spi_flag_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int CNT_W  = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_rd,
    input logic              bus_wr,
    input logic [DATA_W-1:0] bus_rdata,
    input logic              data_acc,
    input logic              ev_done,
    input logic              ev_modf,
    input logic              ev_abrt,
    input logic              irq,
    input logic [CNT_W-1:0]  xfer_bits,
    input logic [NFLAG-1:0]  flags
);
    logic s_rd;
    logic c_wr;
    assign s_rd = bus_rd && (bus_addr == ADDR_W'(4));
    assign c_wr = bus_wr && (bus_addr == ADDR_W'(0));

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_rd |-> (bus_rdata[2:0] == 3'b000 && bus_rdata[DATA_W-1:8] == '0));

    p_abrt_sets_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ev_abrt |=> flags[F_ABRT]);

    p_abrt_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (s_rd && !ev_abrt) |=> !flags[F_ABRT]);

    p_modf_falls_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[F_MODF]) |-> $past(c_wr));

    p_done_falls_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(flags[F_DONE]) |-> $past(data_acc));

    p_done_rises_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(flags[F_DONE]) |-> $past(ev_done));

    p_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_acc && ev_done) |=> flags[F_DONE]);

    p_modf_event_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (c_wr && ev_modf) |=> flags[F_MODF]);

    p_irq_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (flags[F_DONE] || flags[F_MODF]));

    p_bits_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_bits >= CNT_W'(8)) && (xfer_bits <= CNT_W'(16)));
endmodule

bind spi_flag_ctrl spi_flag_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_rd    (bus_rd),
    .bus_wr    (bus_wr),
    .bus_rdata (bus_rdata),
    .data_acc  (data_acc),
    .ev_done   (ev_done),
    .ev_modf   (ev_modf),
    .ev_abrt   (ev_abrt),
    .irq       (irq),
    .xfer_bits (xfer_bits),
    .flags     (flags)
);

// File: tb/spi_flag_ctrl_test.sv
`timescale 1ns/1ps
// Bench: a behavioural reference model, compared with the design in every cycle.
module spi_flag_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic        data_acc = 1'b0;
    logic [4:0]  ev = '0;   // [0] abort, [1] mode fault, [2] overrun, [3] collision, [4] done
    logic        irq;
    logic [4:0]  xfer_bits;

    int n_cmp = 0;
    int n_bad = 0;

    // Model state.
    bit m_flag [5];
    bit m_arm  [5];
    bit m_ien, m_wsel;
    int m_code;

    always #2 clk = ~clk;

    spi_flag_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .data_acc(data_acc),
        .ev_done(ev[4]), .ev_modf(ev[1]), .ev_rovr(ev[2]), .ev_wcol(ev[3]), .ev_abrt(ev[0]),
        .irq(irq), .xfer_bits(xfer_bits)
    );

    function automatic int exp_rdata();
        int v = 0;
        if (!bus_rd) return 0;
        if (bus_addr == 0) return (m_code << 8) | (int'(m_ien) << 7) | (int'(m_wsel) << 2);
        if (bus_addr == 4) begin
            for (int i = 0; i < 5; i++) v |= int'(m_flag[i]) << (i + 3);
            return v;
        end
        return 0;
    endfunction

    function automatic int exp_bits();
        if (!m_wsel) return 8;
        if (m_code == 0) return 16;
        if (m_code >= 8) return m_code;
        return 8;
    endfunction

    task automatic compare(string tag);
        int e_rd = exp_rdata();
        int e_bits = exp_bits();
        bit e_irq = m_ien && (m_flag[4] || m_flag[1]);
        n_cmp += 3;
        if (int'(bus_rdata) != e_rd) begin
            n_bad++;
            $display("FAIL %s rdata actual=%h expected=%h", tag, bus_rdata, e_rd[15:0]);
        end
        if (irq != e_irq) begin
            n_bad++;
            $display("FAIL R8 (%s) irq actual=%0d expected=%0d", tag, irq, e_irq);
        end
        if (int'(xfer_bits) != e_bits) begin
            n_bad++;
            $display("FAIL R9 (%s) xfer_bits actual=%0d expected=%0d", tag, xfer_bits, e_bits);
        end
    endtask

    task automatic model_update();
        bit s_rd = bus_rd && bus_addr == 4;
        bit c_wr = bus_wr && bus_addr == 0;
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) begin m_flag[i] = 0; m_arm[i] = 0; end
            m_ien = 0; m_wsel = 0; m_code = 0;
            return;
        end
        for (int i = 0; i < 5; i++) begin
            bit clr;
            if (ev[i]) begin
                m_flag[i] = 1; m_arm[i] = 0;
            end else if (i == 1 || i == 3 || i == 4) begin
                clr = (i == 1) ? c_wr : data_acc;
                if (clr && m_arm[i]) begin m_flag[i] = 0; m_arm[i] = 0; end
                else if (s_rd) m_arm[i] = m_flag[i];
            end else if (s_rd) begin
                m_flag[i] = 0;
            end
        end
        if (c_wr) begin
            m_ien = bus_wdata[7]; m_wsel = bus_wdata[2]; m_code = int'(bus_wdata[11:8]);
        end
    endtask

    // One clock: drive, compare away from the edge, then advance the model.
    task automatic step(input bit rd, input bit wr, input int addr, input int wd,
                        input bit dacc, input logic [4:0] evs, input string tag);
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_addr = 4'(addr); bus_wdata = 16'(wd);
        data_acc = dacc; ev = evs;
        #1 compare(tag);
        @(posedge clk);
        #0.5 model_update();
    endtask

    task automatic idle(string tag);         step(0, 0, 0, 0, 0, 5'b0, tag); endtask
    task automatic rd_stat(string tag);      step(1, 0, 4, 0, 0, 5'b0, tag); endtask
    task automatic wr_ctrl(int d, string t); step(0, 1, 0, d, 0, 5'b0, t);   endtask
    task automatic dacc(string tag);         step(0, 0, 0, 0, 1, 5'b0, tag); endtask
    task automatic pulse(logic [4:0] e, string tag); step(0, 0, 0, 0, 0, e, tag); endtask
    task automatic clear_all();
        rd_stat("setup"); dacc("setup"); wr_ctrl(0, "setup"); rd_stat("setup");
    endtask

    initial begin : watchdog
        #400000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        model_update();
        step(0, 0, 0, 0, 0, 5'b0, "reset");
        step(0, 0, 0, 0, 0, 5'b0, "reset");
        rst_n = 1'b1;
        idle("R1 reset state");
        rd_stat("R1 status zero after reset");
        step(1, 0, 0, 0, 0, 5'b0, "R1 control zero after reset");

        // R2: every flag set, layout and reserved bits.
        pulse(5'b11111, "R2 set all");
        step(1, 0, 4, 0, 0, 5'b0, "R2 layout 0x00F8");
        // R3: abort and overrun gone after that read.
        rd_stat("R3 one-step cleared");
        clear_all();

        // R4: mode fault needs a read, then a control write.
        pulse(5'b00010, "R4 set");
        wr_ctrl(0, "R4 write without read");
        rd_stat("R4 still set");
        wr_ctrl(0, "R4 armed write");
        rd_stat("R4 cleared");

        // R5: collision and done need a read, then a data access.
        pulse(5'b11000, "R5 set");
        dacc("R5 access without read");
        rd_stat("R5 still set");
        dacc("R5 armed access");
        rd_stat("R5 cleared");

        // R6: a read taken before the flag set does not arm it.
        rd_stat("R6 read while clear");
        pulse(5'b10000, "R6 set after read");
        dacc("R6 access");
        rd_stat("R6 still set");
        dacc("R6 clear");
        rd_stat("R6 cleared");

        // R7: an event in the clearing cycle wins and drops the armed state.
        pulse(5'b10000, "R7 set");
        rd_stat("R7 arm");
        step(0, 0, 0, 0, 1, 5'b10000, "R7 collide");
        dacc("R7 access after collide");
        rd_stat("R7 still set");
        dacc("R7 clear");
        rd_stat("R7 cleared");
        pulse(5'b00010, "R7 modf set");
        rd_stat("R7 modf arm");
        step(0, 1, 0, 0, 0, 5'b00010, "R7 modf collide");
        rd_stat("R7 modf still set");
        clear_all();

        // R8: interrupt gating and sources.
        wr_ctrl(16'h0080, "R8 enable");
        pulse(5'b01101, "R8 non-source flags");
        idle("R8 no irq from others");
        clear_all();
        wr_ctrl(16'h0080, "R8 enable");
        pulse(5'b10000, "R8 done source");
        idle("R8 irq high");
        wr_ctrl(16'h0000, "R8 disable");
        idle("R8 irq masked");
        wr_ctrl(16'h0080, "R8 re-enable");
        rd_stat("R8 arm");
        dacc("R8 clear done");
        pulse(5'b00010, "R8 modf source");
        idle("R8 irq from modf");
        clear_all();

        // R9: every code with the selection on and off.
        for (int c = 0; c < 16; c++) begin
            wr_ctrl((c << 8) | 16'h0004, "R9 select on");
            idle("R9 decode on");
            wr_ctrl(c << 8, "R9 select off");
            idle("R9 decode off");
        end

        // R10: control read-back, unmapped addresses and idle read data.
        wr_ctrl(16'hFFFF, "R10 write all ones");
        step(1, 0, 0, 0, 0, 5'b0, "R10 readback 0x0F84");
        step(0, 1, 8, 16'h0000, 0, 5'b0, "R10 unmapped write");
        step(1, 0, 8, 0, 0, 5'b0, "R10 unmapped read");
        step(1, 0, 0, 0, 0, 5'b0, "R10 control unchanged");
        pulse(5'b11111, "R10 set flags");
        idle("R10 rdata zero without read");
        step(1, 0, 12, 0, 0, 5'b0, "R10 unmapped read with flags");
        rd_stat("R10 status still visible");

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule